// File: doc/BRIEF.md
# ADC Handshake Temperature Converter

This block sits between an external 8-bit parallel analog-to-digital converter and the decision and display logic of a thermostat. It starts the converter once after reset, watches the converter's end-of-conversion line, and on every new conversion it opens the converter's tri-state output for one clock and latches the bus. The analog front end is scaled so that code 0 means -40 °C. The block therefore removes an offset of 40 by adding its two's complement to the raw code.

The result is turned into an 8-bit sign-magnitude temperature, with bit 7 as the sign and bits 6:0 as the magnitude. The same value is also given as four 4-bit fields: a sign code, then hundreds, tens and ones in BCD. A downstream comparator or display driver reads these fields.

The result leaves the block as a single-cycle `valid_o` strobe over held data fields. There is no ready input and no back-pressure. A consumer that needs the event must take it in the strobe cycle. A consumer that only needs the latest value can read the fields at any time, because they hold until the next strobe. `start_o` and `oe_o` are plain control pins toward the converter.

Top module: `adc_temp_conv`

## Requirements
- R1: `start_o` is high for exactly the first clock cycle after reset is released, and never again until the next reset.
- R2: `eoc_i` passes through a two-flop synchronizer. A low-to-high change of `eoc_i` that is present at clock edge k makes `oe_o` high for exactly one cycle, from edge k+2 to edge k+3. Holding `eoc_i` high does not raise `oe_o` again.
- R3: `adc_data_i` is sampled at the clock edge that ends the `oe_o` cycle. Bus values at other edges have no effect on the outputs.
- R4: The temperature is the sampled code minus 40, formed by adding the two's complement of 40.
- R5: A non-negative temperature up to 127 appears on `temp_sm_o` unchanged with bit 7 at 0. A temperature above 127 saturates to 127.
- R6: A negative temperature appears on `temp_sm_o` with bit 7 at 1 and bits 6:0 holding its magnitude, which is between 1 and 40.
- R7: `bcd_sign_o` is 4'b0000 for a non-negative result and 4'b1110 for a negative result.
- R8: `bcd_hund_o`, `bcd_tens_o` and `bcd_ones_o` are the BCD hundreds, tens and ones digits of the magnitude in bits 6:0 of `temp_sm_o`.
- R9: `valid_o` is a one-cycle pulse, high exactly two cycles after `oe_o` was high, in the cycle in which the new fields first appear. Between pulses all data outputs hold.
- R10: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc_i | input | 1 | End-of-conversion from the converter, asynchronous |
| adc_data_i | input | 8 | Converter parallel output bus |
| start_o | output | 1 | One-time start-conversion pulse |
| oe_o | output | 1 | Converter output enable, one cycle per conversion |
| temp_sm_o | output | 8 | Temperature in sign-magnitude form, bit 7 = sign |
| bcd_sign_o | output | 4 | Sign field: 0000 non-negative, 1110 negative |
| bcd_hund_o | output | 4 | Hundreds digit, BCD |
| bcd_tens_o | output | 4 | Tens digit, BCD |
| bcd_ones_o | output | 4 | Ones digit, BCD |
| valid_o | output | 1 | One-cycle strobe: new result on the data outputs |

## Verification
The assertions check the following on every cycle: `start_o` and `oe_o` are single pulses, the start pulse occurs only once per reset, `valid_o` trails `oe_o` by two cycles, and the data outputs hold between strobes. They also check that the sign field agrees with bit 7, that every digit is a legal BCD value, and that a negative magnitude stays within the offset. The exact numbers can only be shown by the bench's scenarios. These cover the offset arithmetic, the saturation above 127, the digit values at the decade and hundred boundaries, and which bus sample is taken when the bus changes every cycle. The same applies to the synchronizer latency and the absence of a second capture while end-of-conversion is held high.

// File: rtl/adc_tc_pkg.sv
package adc_tc_pkg;
  localparam logic [3:0] SIGN_POS = 4'b0000;
  localparam logic [3:0] SIGN_NEG = 4'b1110;
  localparam int NIB_W = 4;
endpackage

// File: rtl/adc_tc_sync.sv
module adc_tc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_tc_hshk.sv
module adc_tc_hshk (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_s_i,
  output logic start_o,
  output logic oe_o
);
  logic started_q, start_q, eoc_prev_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q  <= 1'b0;
      start_q    <= 1'b0;
      eoc_prev_q <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      started_q  <= 1'b1;
      start_q    <= ~started_q;
      eoc_prev_q <= eoc_s_i;
      oe_q       <= eoc_s_i & ~eoc_prev_q;
    end
  end

  assign start_o = start_q;
  assign oe_o    = oe_q;
endmodule

// File: rtl/adc_tc_fold.sv
module adc_tc_fold #(
  parameter int W      = 8,
  parameter int OFFSET = 40
) (
  input  logic [W-1:0] raw_i,
  output logic         neg_o,
  output logic [W-2:0] mag_o
);
  localparam int         OFF_TC_I = (1 << W) - OFFSET;
  localparam logic [W:0] OFF_TC   = OFF_TC_I[W:0];

  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic [W-2:0] neg_mag;

  // adding the two's complement: carry out means the result is non-negative
  assign sum     = {1'b0, raw_i} + OFF_TC;
  assign neg_o   = ~sum[W];
  assign diff    = sum[W-1:0];
  assign neg_mag = ~diff[W-2:0] + (W-1)'(1);

  always_comb begin
    if (neg_o)        mag_o = neg_mag;
    else if (diff[W-1]) mag_o = '1;
    else              mag_o = diff[W-2:0];
  end
endmodule

// File: rtl/adc_tc_bcd.sv
module adc_tc_bcd #(
  parameter int BIN_W  = 7,
  parameter int DIGITS = 3
) (
  input  logic [BIN_W-1:0]    bin_i,
  output logic [DIGITS*4-1:0] bcd_o
);
  localparam int ACC_W = BIN_W + DIGITS*4;

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    acc[BIN_W-1:0] = bin_i;
    for (int i = 0; i < BIN_W; i++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[BIN_W+4*d +: 4] > 4'd4)
          acc[BIN_W+4*d +: 4] = acc[BIN_W+4*d +: 4] + 4'd3;
      end
      acc = acc << 1;
    end
    bcd_o = acc[BIN_W +: DIGITS*4];
  end
endmodule

// File: rtl/adc_temp_conv.sv
module adc_temp_conv
  import adc_tc_pkg::*;
#(
  parameter int ADC_W       = 8,
  parameter int OFFSET      = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoc_i,
  input  logic [ADC_W-1:0] adc_data_i,
  output logic             start_o,
  output logic             oe_o,
  output logic [ADC_W-1:0] temp_sm_o,
  output logic [3:0]       bcd_sign_o,
  output logic [3:0]       bcd_hund_o,
  output logic [3:0]       bcd_tens_o,
  output logic [3:0]       bcd_ones_o,
  output logic             valid_o
);
  localparam int MAG_W  = ADC_W - 1;
  localparam int DIGITS = 3;

  logic                  eoc_s;
  logic [ADC_W-1:0]      raw_q;
  logic                  cap_q;
  logic                  neg;
  logic [MAG_W-1:0]      mag;
  logic [DIGITS*4-1:0]   dec;

  adc_tc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(eoc_i), .q_o(eoc_s)
  );

  adc_tc_hshk u_hshk (
    .clk(clk), .rst_n(rst_n), .eoc_s_i(eoc_s), .start_o(start_o), .oe_o(oe_o)
  );

  // capture stage: bus read while the converter drives it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      cap_q <= 1'b0;
    end else begin
      cap_q <= oe_o;
      if (oe_o) raw_q <= adc_data_i;
    end
  end

  adc_tc_fold #(.W(ADC_W), .OFFSET(OFFSET)) u_fold (
    .raw_i(raw_q), .neg_o(neg), .mag_o(mag)
  );

  adc_tc_bcd #(.BIN_W(MAG_W), .DIGITS(DIGITS)) u_bcd (
    .bin_i(mag), .bcd_o(dec)
  );

  // result stage: fields update together with the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_sm_o  <= '0;
      bcd_sign_o <= '0;
      bcd_hund_o <= '0;
      bcd_tens_o <= '0;
      bcd_ones_o <= '0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= cap_q;
      if (cap_q) begin
        temp_sm_o  <= {neg, mag};
        bcd_sign_o <= neg ? SIGN_NEG : SIGN_POS;
        bcd_hund_o <= dec[2*NIB_W +: NIB_W];
        bcd_tens_o <= dec[NIB_W +: NIB_W];
        bcd_ones_o <= dec[0 +: NIB_W];
      end
    end
  end
endmodule

// File: rtl/adc_tc_chk.sv
module adc_tc_chk #(
  parameter int W      = 8,
  parameter int OFFSET = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_o,
  input logic         oe_o,
  input logic [W-1:0] temp_sm_o,
  input logic [3:0]   bcd_sign_o,
  input logic [3:0]   bcd_hund_o,
  input logic [3:0]   bcd_tens_o,
  input logic [3:0]   bcd_ones_o,
  input logic         valid_o
);
  logic start_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       start_seen_q <= 1'b0;
    else if (start_o) start_seen_q <= 1'b1;
  end

  // R1
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !start_seen_q);

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R2
  oe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |=> !oe_o);

  // R9
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == $past(oe_o, 2));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(temp_sm_o) && $stable(bcd_sign_o) && $stable(bcd_hund_o)
                  && $stable(bcd_tens_o) && $stable(bcd_ones_o)));

  // R7
  sign_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_sign_o == (temp_sm_o[W-1] ? 4'b1110 : 4'b0000));

  // R8
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd_hund_o <= 4'd9) && (bcd_tens_o <= 4'd9) && (bcd_ones_o <= 4'd9));

  // R6
  neg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    temp_sm_o[W-1] |-> ((temp_sm_o[W-2:0] != '0) && (int'(temp_sm_o[W-2:0]) <= OFFSET)));
endmodule

bind adc_temp_conv adc_tc_chk #(.W(ADC_W), .OFFSET(OFFSET)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_o(start_o), .oe_o(oe_o),
  .temp_sm_o(temp_sm_o), .bcd_sign_o(bcd_sign_o), .bcd_hund_o(bcd_hund_o),
  .bcd_tens_o(bcd_tens_o), .bcd_ones_o(bcd_ones_o), .valid_o(valid_o)
);

// File: tb/adc_temp_conv_tb_top.sv
`timescale 1ns/1ps
module adc_temp_conv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       eoc_i = 1'b0;
  logic [7:0] adc_data_i = 8'h00;
  logic       start_o, oe_o, valid_o;
  logic [7:0] temp_sm_o;
  logic [3:0] bcd_sign_o, bcd_hund_o, bcd_tens_o, bcd_ones_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  adc_temp_conv dut_i (
    .clk(clk), .rst_n(rst_n), .eoc_i(eoc_i), .adc_data_i(adc_data_i),
    .start_o(start_o), .oe_o(oe_o), .temp_sm_o(temp_sm_o),
    .bcd_sign_o(bcd_sign_o), .bcd_hund_o(bcd_hund_o), .bcd_tens_o(bcd_tens_o),
    .bcd_ones_o(bcd_ones_o), .valid_o(valid_o)
  );

  // reference model state
  int hist[$];
  int edges;
  bit m_start, m_oe, m_cap, m_valid;
  int m_raw;
  int m_sm, m_sign, m_h, m_t, m_o;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R4, R5, R6, R7, R8 reference arithmetic
  task automatic convert(int raw);
    int v, mag;
    v = raw - 40;
    if (v < 0) begin
      mag = -v; m_sm = 128 + mag; m_sign = 14;
    end else begin
      mag = (v > 127) ? 127 : v; m_sm = mag; m_sign = 0;
    end
    m_h = mag / 100;
    m_t = (mag / 10) % 10;
    m_o = mag % 10;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {0, 0, 0};
      edges = 0;
      m_start = 0; m_oe = 0; m_cap = 0; m_valid = 0; m_raw = 0;
      m_sm = 0; m_sign = 0; m_h = 0; m_t = 0; m_o = 0;
    end else begin
      edges++;
      hist.push_front(int'(eoc_i));
      m_valid = m_cap;
      if (m_cap) convert(m_raw);
      m_cap = m_oe;
      if (m_oe) m_raw = int'(adc_data_i);
      m_oe = (hist[2] == 1) && (hist[3] == 0);
      void'(hist.pop_back());
      m_start = (edges == 1);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check(start_o == m_start, "R1 start_o", start_o, m_start);
      check(oe_o == m_oe, "R2 oe_o", oe_o, m_oe);
      check(valid_o == m_valid, "R9 valid_o", valid_o, m_valid);
      if (m_sm >= 128) check(temp_sm_o == m_sm, "R6 temp_sm_o", temp_sm_o, m_sm);
      else             check(temp_sm_o == m_sm, "R5 temp_sm_o", temp_sm_o, m_sm);
      check(bcd_sign_o == m_sign, "R7 bcd_sign_o", bcd_sign_o, m_sign);
      check(bcd_hund_o == m_h, "R8 hundreds", bcd_hund_o, m_h);
      check(bcd_tens_o == m_t, "R8 tens", bcd_tens_o, m_t);
      check(bcd_ones_o == m_o, "R8 ones", bcd_ones_o, m_o);
    end
  end

  task automatic reset_check();
    @(negedge clk);
    check(start_o == 0 && oe_o == 0 && valid_o == 0, "R10 controls", {start_o, oe_o, valid_o}, 0);
    check(temp_sm_o == 0, "R10 temp_sm_o", temp_sm_o, 0);
    check({bcd_sign_o, bcd_hund_o, bcd_tens_o, bcd_ones_o} == 0, "R10 bcd", 
          {bcd_sign_o, bcd_hund_o, bcd_tens_o, bcd_ones_o}, 0);
  endtask

  // R3: bus value is set only for the conversion; other cycles carry junk
  task automatic conversion(int val, int hold);
    @(negedge clk);
    adc_data_i = 8'(val);
    eoc_i = 1'b1;
    repeat (hold) @(negedge clk);
    eoc_i = 1'b0;
    repeat (5) @(negedge clk);
    adc_data_i = 8'hA5;
  endtask

  initial begin
    int vals[12] = '{0, 39, 40, 41, 65, 139, 140, 149, 167, 168, 255, 1};
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    reset_check();
    cmp_en = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R4 R5 R6 R7 R8: offset, fold, saturation, digit boundaries
    foreach (vals[i]) conversion(vals[i], 4);
    // R2: long high level gives a single capture
    conversion(100, 25);
    // R3: bus changes every cycle; model decides which sample is taken
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      adc_data_i = 8'(n * 37 + 11);
      eoc_i = (n % 7 == 2);
    end
    eoc_i = 1'b0;
    repeat (6) @(negedge clk);
    // R10 and R1: reset mid-run, start pulse reappears once
    rst_n = 1'b0;
    reset_check();
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    conversion(10, 1);
    conversion(200, 2);
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule